// File: doc/BRIEF.md
# Coded-Operation Integer Arithmetic and Logic Unit

This block is a purely combinational 32-bit arithmetic and logic unit for a small multi-cycle processor datapath. It takes two operands and a 6-bit operation code, and it returns a 32-bit result together with a flag that is high whenever that result is zero. The control logic chooses the code. Besides the plain arithmetic and logic instructions, the datapath reuses the same codes for its other jobs. Equality branches use subtraction and then test the flag. Load and store addresses are formed with addition. Stack push and pop use subtraction or addition with a second operand of 1.

Only codes 1 through 9 carry an operation. Every other code returns a result of zero. The shift instructions take their distance from the low bits of operand B. Set-less-than compares the operands as two's-complement values.

Top module: `alu_core`

## Requirements
- R1: With `opc_i` = 1 the result is `opa_i + opb_i` modulo 2^32; with `opb_i` = 1 this gives the stack-pointer increment.
- R2: With `opc_i` = 2 the result is `opa_i - opb_i` modulo 2^32, so a borrow wraps around (0 - 1 = 0xFFFFFFFF).
- R3: With `opc_i` = 3 the result is the low 32 bits of the unsigned product `opa_i * opb_i`.
- R4: With `opc_i` = 4 the result is `opa_i` shifted right logically, with zero fill, by `opb_i[4:0]`; bits 31..5 of `opb_i` have no effect.
- R5: With `opc_i` = 5 the result is `opa_i` shifted left logically, with zero fill, by `opb_i[4:0]`; bits 31..5 of `opb_i` have no effect.
- R6: Codes 6, 7 and 8 give the bitwise AND, OR and NOR of the two operands.
- R7: With `opc_i` = 9 the result is 1 when `opa_i` is less than `opb_i` as signed two's-complement values and 0 otherwise; bits 31..1 of the result are always 0, including when the difference overflows.
- R8: Code 0 and codes 10 to 63 give a result of 0, so `zero_o` is 1 for them.
- R9: `zero_o` is 1 exactly when all 32 result bits are 0. After a subtract, this makes `zero_o` high for equal operands (branch-equal taken) and low for unequal ones (branch-not-equal taken).
- R10: The outputs depend only on the present inputs; the operations applied earlier have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opc_i | input | 6 | Operation code (1..9 valid) |
| opa_i | input | 32 | Operand A, the shifted value for shifts |
| opb_i | input | 32 | Operand B, the shift distance in bits 4..0 for shifts |
| res_o | output | 32 | Result |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
Each operation is driven with small values, which show that the right code picks the right unit. Wrap-around values such as all-ones plus one, zero minus one and 2^16 squared separate true modulo-2^32 behaviour from widened arithmetic. Shift distances of 0, 31 and values with bits set above bit 4 show that only five bits select the distance. Set-less-than is driven with sign-mixed and overflowing pairs, which tell a signed compare from an unsigned one and from the raw sign of the difference. Undefined codes, equal and unequal compares, and increments and decrements of a stack pointer then check the zero flag and the code map at their edges.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned OPC_W = 6;

    typedef enum logic [OPC_W-1:0] {
        OP_NONE = 6'd0,
        OP_ADD  = 6'd1,
        OP_SUB  = 6'd2,
        OP_MUL  = 6'd3,
        OP_SRL  = 6'd4,
        OP_SLL  = 6'd5,
        OP_AND  = 6'd6,
        OP_OR   = 6'd7,
        OP_NOR  = 6'd8,
        OP_SLT  = 6'd9
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              ovf_o
);
    localparam int unsigned MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_x;

    always_comb begin
        b_x   = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_x + {{(DATA_W-1){1'b0}}, sub_i};
        ovf_o = (a_i[MSB] == b_x[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end

    // The difference added back to B must give A.
    always_comb begin
        if (sub_i) begin
            assert_sub_inverse_R2: assert ((sum_o + b_i) == a_i)
                else $error("difference does not invert");
        end
    end

endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] prod_o
);
    always_comb begin
        prod_o = a_i * b_i;
    end

    always_comb begin
        if (b_i == {{(DATA_W-1){1'b0}}, 1'b1}) begin
            assert_mul_identity_R3: assert (prod_o == a_i)
                else $error("product by one differs from operand");
        end
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              left_i,
    output logic [DATA_W-1:0] val_o
);
    logic [DATA_W-1:0] val_rev;
    logic [DATA_W-1:0] stage [AMT_W+1];
    logic [DATA_W-1:0] out_rev;

    // Mirror the bits so that one left-shifting ladder serves both directions.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign val_rev[i] = val_i[DATA_W-1-i];
        assign out_rev[i] = stage[AMT_W][DATA_W-1-i];
    end

    assign stage[0] = left_i ? val_i : val_rev;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        assign stage[s+1] = amt_i[s] ? (stage[s] << (1 << s)) : stage[s];
    end

    assign val_o = left_i ? stage[AMT_W] : out_rev;

    always_comb begin
        assert_shift_ones_R4: assert ($countones(val_o) <= $countones(val_i))
            else $error("logical shift created set bits");
        if (amt_i == '0) begin
            assert_shift_zero_R5: assert (val_o == val_i)
                else $error("zero-distance shift altered value");
        end
    end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] and_o,
    output logic [DATA_W-1:0] or_o,
    output logic [DATA_W-1:0] nor_o
);
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        nor_o = ~or_o;
    end

    always_comb begin
        assert_and_within_or_R6: assert ((and_o & ~or_o) == '0)
            else $error("AND bit set outside OR");
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    output logic [DATA_W-1:0] res_o,
    output logic              zero_o
);
    localparam int unsigned AMT_W = $clog2(DATA_W);
    localparam int unsigned MSB   = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              zero;
    } alu_out_t;

    logic              sub_sel;
    logic              left_sel;
    logic [DATA_W-1:0] sum;
    logic              ovf;
    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] r_and;
    logic [DATA_W-1:0] r_or;
    logic [DATA_W-1:0] r_nor;
    logic              less;
    alu_out_t          out_d;

    // Set-less-than and subtract share the single adder.
    assign sub_sel  = (opc_i == OP_SUB) || (opc_i == OP_SLT);
    assign left_sel = (opc_i == OP_SLL);

    alu_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sub_i (sub_sel),
        .sum_o (sum),
        .ovf_o (ovf)
    );

    alu_mul #(.DATA_W(DATA_W)) mul_i (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .prod_o (prod)
    );

    alu_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) shift_i (
        .val_i  (opa_i),
        .amt_i  (opb_i[AMT_W-1:0]),
        .left_i (left_sel),
        .val_o  (shifted)
    );

    alu_bitwise #(.DATA_W(DATA_W)) bitwise_i (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .and_o (r_and),
        .or_o  (r_or),
        .nor_o (r_nor)
    );

    // Signed order: sign of the difference, corrected when it overflowed.
    assign less = sum[MSB] ^ ovf;

    always_comb begin
        out_d = '0;
        case (opc_i)
            OP_ADD,
            OP_SUB:  out_d.res = sum;
            OP_MUL:  out_d.res = prod;
            OP_SRL,
            OP_SLL:  out_d.res = shifted;
            OP_AND:  out_d.res = r_and;
            OP_OR:   out_d.res = r_or;
            OP_NOR:  out_d.res = r_nor;
            OP_SLT:  out_d.res = {{(DATA_W-1){1'b0}}, less};
            default: out_d.res = '0;
        endcase
        out_d.zero = (out_d.res == '0);
    end

    assign res_o  = out_d.res;
    assign zero_o = out_d.zero;

    always_comb begin
        if (opc_i == OP_SLT) begin
            assert_slt_bit0_only_R7: assert (res_o[DATA_W-1:1] == '0)
                else $error("compare set upper result bits");
        end
        if ((opc_i == OP_NONE) || (opc_i > OP_SLT)) begin
            assert_undef_code_zero_R8: assert (zero_o && (res_o == '0))
                else $error("undefined code gave nonzero result");
        end
        if (sub_sel && (opa_i == opb_i)) begin
            assert_equal_sets_zero_R9: assert (zero_o)
                else $error("equal compare without zero flag");
        end
    end

endmodule

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;

    localparam int NVEC = 26;
    localparam int VW   = 6 + 32 + 32 + 32;

    // {code, operand A, operand B, expected result}
    localparam logic [VW-1:0] VECS [NVEC] = '{
        {6'd1,  32'h0000_0005, 32'h0000_0003, 32'h0000_0008},
        {6'd1,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
        {6'd2,  32'h0000_000A, 32'h0000_0003, 32'h0000_0007},
        {6'd2,  32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF},
        {6'd2,  32'h1234_5678, 32'h1234_5678, 32'h0000_0000},
        {6'd3,  32'h0000_0007, 32'h0000_0006, 32'h0000_002A},
        {6'd3,  32'h0001_0000, 32'h0001_0000, 32'h0000_0000},
        {6'd3,  32'hFFFF_FFFF, 32'h0000_0002, 32'hFFFF_FFFE},
        {6'd4,  32'h8000_0000, 32'h0000_0004, 32'h0800_0000},
        {6'd4,  32'hF000_0000, 32'h0000_0024, 32'h0F00_0000},
        {6'd4,  32'h8000_0000, 32'h0000_001F, 32'h0000_0001},
        {6'd5,  32'h0000_0001, 32'h0000_001F, 32'h8000_0000},
        {6'd5,  32'h0000_0003, 32'h0000_0020, 32'h0000_0003},
        {6'd5,  32'hFFFF_FFFF, 32'h0000_0008, 32'hFFFF_FF00},
        {6'd6,  32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},
        {6'd7,  32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0},
        {6'd8,  32'hF0F0_F0F0, 32'hFF00_FF00, 32'h000F_000F},
        {6'd8,  32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000},
        {6'd9,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
        {6'd9,  32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},
        {6'd9,  32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001},
        {6'd9,  32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000},
        {6'd9,  32'h0000_0005, 32'h0000_0005, 32'h0000_0000},
        {6'd0,  32'h0000_0005, 32'h0000_0003, 32'h0000_0000},
        {6'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
        {6'd63, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opc = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] res;
    logic        zero;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    alu_core dut_i (
        .opc_i  (opc),
        .opa_i  (opa),
        .opb_i  (opb),
        .res_o  (res),
        .zero_o (zero)
    );

    function automatic string tag_of(input logic [5:0] c);
        case (c)
            6'd1: return "R1";
            6'd2: return "R2";
            6'd3: return "R3";
            6'd4: return "R4";
            6'd5: return "R5";
            6'd6, 6'd7, 6'd8: return "R6";
            6'd9: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic drive(input logic [5:0] c, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        opc = c;
        opa = a;
        opb = b;
        @(negedge clk);
    endtask

    task automatic check_res(input string tag, input logic [31:0] exp);
        n_checks++;
        if (res !== exp) begin
            n_fail++;
            $display("FAIL %s: code %0d res=%08h expected=%08h", tag, opc, res, exp);
        end
    endtask

    task automatic check_zero(input string tag, input logic exp);
        n_checks++;
        if (zero !== exp) begin
            n_fail++;
            $display("FAIL %s: code %0d zero=%0b expected=%0b", tag, opc, zero, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // Idle state: code 0 with zero operands (R8).
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_res("R8", 32'h0);
        check_zero("R8", 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            logic [5:0]  c;
            logic [31:0] a;
            logic [31:0] b;
            logic [31:0] e;
            {c, a, b, e} = VECS[i];
            drive(c, a, b);
            check_res(tag_of(c), e);
            check_zero("R9", e == 32'h0);
        end

        // Branch decisions through subtract (R9).
        drive(6'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        check_zero("R9", 1'b1);
        drive(6'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
        check_zero("R9", 1'b0);

        // Stack pointer increment and decrement (R1, R2).
        drive(6'd1, 32'h0000_0100, 32'h0000_0001);
        check_res("R1", 32'h0000_0101);
        drive(6'd2, 32'h0000_0100, 32'h0000_0001);
        check_res("R2", 32'h0000_00FF);

        // Upper distance bits ignored for a left shift (R5).
        drive(6'd5, 32'h0000_0001, 32'hFFFF_FFE4);
        check_res("R5", 32'h0000_0010);

        // Result after a multiply depends only on present inputs (R10).
        drive(6'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check_res("R3", 32'h0000_0001);
        drive(6'd6, 32'h0000_00FF, 32'h0000_0F0F);
        check_res("R10", 32'h0000_000F);
        check_zero("R10", 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule